// File: doc/BRIEF.md
# Banked Register File with Deferred Configuration

This block is the register and memory access layer of a small peripheral with an 8-bit data path. A host presents single-cycle accesses made of a 2-bit bank number and an 8-bit offset. Four banks sit behind that address. Bank 0 is a 16-byte one-time-programmable array, modelled as flops whose bits can only be set. Bank 1 holds two control/status registers. Bank 2 holds three authentication registers. Bank 3 is a protected test bank of eight scratch bytes.

The first two array bytes hold the configuration and trim settings. They feed a live configuration copy that drives the block's configuration outputs. That copy is reloaded only at power-on reset or when the host pulses a soft-reset input, so programming the array has no effect on behaviour until one of those events. The twelve secret bytes in the array cannot be read over the host port. They leave the block on a wide internal bus meant for an authentication engine.

Read data and the bus-error indication are combinational in the access cycle. Writes take effect at the clock edge that ends the access.

Top module: `cfg_regbank`

## Requirements
- R1: Bank 0 implements offsets 0x00 to 0x0F. Bank 1 implements offsets 0x00 and 0x01. Bank 2 implements offsets 0x00 to 0x02. A read of an implemented, readable location returns its stored byte on `rd_data` in the same cycle.
- R2: A write to bank 0 stores old OR written data. A bit that has been set can never be cleared.
- R3: The bank 1 and bank 2 registers are plain read/write bytes and reset to 0x00.
- R4: An access to an unimplemented location changes no state, reads 0x00 and leaves `bus_err` low.
- R5: Any access to bank 3 while `test_mode` is low raises `bus_err` for exactly that access cycle, reads 0x00 and changes no state.
- R6: While `test_mode` is high, bank 3 offsets 0x00 to 0x07 are read/write scratch bytes that reset to 0x00. Higher offsets are unimplemented, and `bus_err` stays low.
- R7: A bank 0 write leaves every live configuration output unchanged until the next soft reset or power-on reset.
- R8: A soft-reset pulse copies array byte 0x00 into {`cfg_hi_sel`[7:6], `cfg_speed`[5:4], `cfg_irq_en`[3], `cfg_auto_sleep`[2], `cfg_lo_sel`[1:0]}. It copies byte 0x01 into {`trim_flag`[7], `trim_bias`[6:4], `trim_osc`[3:0]}. The new values appear after the clock edge.
- R9: Bank 0 offsets 0x02 to 0x0D read 0x00 on the host port. The byte at offset 0x02+k is driven on `secret_key`[8k+7:8k].
- R10: Power-on reset sets array byte 0x00 to 0x24 and byte 0x01 to 0x08, sets all other array bytes to 0x00, and loads the live configuration from those defaults.
- R11: When a soft reset and a bank 0 write fall in the same cycle, the live copy takes the array contents from before the write, and the write still lands in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| soft_rst | input | 1 | One-cycle request to reload the live configuration |
| test_mode | input | 1 | Unlocks bank 3 |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_bank | input | 2 | Bank number |
| acc_offset | input | 8 | Offset inside the bank |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid during a read strobe |
| bus_err | output | 1 | Rejected-access pulse |
| cfg_hi_sel | output | 2 | Live configuration bits [7:6] |
| cfg_speed | output | 2 | Live speed field |
| cfg_irq_en | output | 1 | Live interrupt enable |
| cfg_auto_sleep | output | 1 | Live auto-sleep enable |
| cfg_lo_sel | output | 2 | Live configuration bits [1:0] |
| trim_flag | output | 1 | Live trim flag |
| trim_bias | output | 3 | Live bias trim |
| trim_osc | output | 4 | Live oscillator trim |
| secret_key | output | 96 | Secret array bytes for the authentication engine |

## Verification
The interaction that matters is a bank 0 write to the configuration or trim byte in the same cycle as a soft-reset pulse. Here the live-copy reload and the array update race at one clock edge. The bench forces this case directly on both bytes. It also lets the random phase strike soft reset on top of random array writes. Each outcome is judged against a model that snapshots the array before applying the write. A later plain soft reset then shows that the write itself was kept.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_OTP,
    RGN_CTRL,
    RGN_AUTH,
    RGN_TEST,
    RGN_DENY
  } region_e;

  // one-time-programmable merge: bits can only be set
  function automatic logic [DW-1:0] otp_merge(input logic [DW-1:0] old_v,
                                              input logic [DW-1:0] wr_v);
    return old_v | wr_v;
  endfunction

  // true when an array offset lies in the hidden secret window
  function automatic logic in_secret(input logic [7:0] off,
                                     input int first, input int count);
    return (int'(off) >= first) && (int'(off) < first + count);
  endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import cfg_regbank_pkg::*;
#(
  parameter int OTP_DEPTH = 16,
  parameter int CTRL_REGS = 2,
  parameter int AUTH_REGS = 3,
  parameter int TEST_REGS = 8
) (
  input  logic       valid,
  input  logic [1:0] bank,
  input  logic [7:0] offset,
  input  logic       test_mode,
  output region_e    region,
  output logic       deny
);
  localparam logic [7:0] OTP_LIM  = 8'(OTP_DEPTH);
  localparam logic [7:0] CTRL_LIM = 8'(CTRL_REGS);
  localparam logic [7:0] AUTH_LIM = 8'(AUTH_REGS);
  localparam logic [7:0] TEST_LIM = 8'(TEST_REGS);

  always_comb begin
    region = RGN_NONE;
    unique case (bank)
      2'd0: if (offset < OTP_LIM)  region = RGN_OTP;
      2'd1: if (offset < CTRL_LIM) region = RGN_CTRL;
      2'd2: if (offset < AUTH_LIM) region = RGN_AUTH;
      2'd3: begin
        if (!test_mode)             region = RGN_DENY;
        else if (offset < TEST_LIM) region = RGN_TEST;
      end
      default: region = RGN_NONE;
    endcase
  end

  assign deny = valid && (region == RGN_DENY);

endmodule

// File: rtl/rb_plain_regs.sv
module rb_plain_regs
  import cfg_regbank_pkg::*;
#(
  parameter int NUM = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [NUM-1:0][DW-1:0] regs;

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[i] <= '0;
      else if (wr_en && idx == 8'(i))     regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM; i++)
      if (idx == 8'(i)) rdata = regs[i];
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs)); // R3

endmodule

// File: rtl/rb_otp_array.sv
module rb_otp_array
  import cfg_regbank_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter logic [7:0]  DEF_CFG  = 8'h24,
  parameter logic [7:0]  DEF_TRIM = 8'h08
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                idx,
  input  logic [DW-1:0]             wdata,
  output logic [DEPTH-1:0][DW-1:0]  mem
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [DW-1:0] INIT = (i == 0) ? DEF_CFG :
                                     (i == 1) ? DEF_TRIM : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mem[i] <= INIT;
      else if (wr_en && idx == 8'(i))  mem[i] <= otp_merge(mem[i], wdata);
    end
  end

  AST_OTP_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (~mem & $past(mem)) == '0); // R2

endmodule

// File: rtl/rb_live_cfg.sv
module rb_live_cfg
  import cfg_regbank_pkg::*;
#(
  parameter logic [7:0] DEF_CFG  = 8'h24,
  parameter logic [7:0] DEF_TRIM = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [DW-1:0] src_cfg,
  input  logic [DW-1:0] src_trim,
  output logic [DW-1:0] live_cfg,
  output logic [DW-1:0] live_trim
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cfg  <= DEF_CFG;
      live_trim <= DEF_TRIM;
    end else if (soft_rst) begin
      live_cfg  <= src_cfg;
      live_trim <= src_trim;
    end
  end

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> $stable({live_cfg, live_trim})); // R7

  AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> {live_cfg, live_trim} == $past({src_cfg, src_trim})); // R11

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter int         OTP_DEPTH = 16,
  parameter int         CTRL_REGS = 2,
  parameter int         AUTH_REGS = 3,
  parameter int         TEST_REGS = 8,
  parameter logic [7:0] DEF_CFG   = 8'h24,
  parameter logic [7:0] DEF_TRIM  = 8'h08,
  parameter int         SEC_FIRST = 2,
  parameter int         SEC_N     = OTP_DEPTH - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              test_mode,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_bank,
  input  logic [7:0]        acc_offset,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        rd_data,
  output logic              bus_err,
  output logic [1:0]        cfg_hi_sel,
  output logic [1:0]        cfg_speed,
  output logic              cfg_irq_en,
  output logic              cfg_auto_sleep,
  output logic [1:0]        cfg_lo_sel,
  output logic              trim_flag,
  output logic [2:0]        trim_bias,
  output logic [3:0]        trim_osc,
  output logic [8*SEC_N-1:0] secret_key
);
  localparam int OIW = $clog2(OTP_DEPTH);

  region_e                      region;
  logic                         deny;
  logic                         wr_any;
  logic                         rd_any;
  logic [OTP_DEPTH-1:0][DW-1:0] otp_mem;
  logic [DW-1:0]                ctrl_rd, auth_rd, test_rd, rd_mux;
  logic [DW-1:0]                live_cfg, live_trim;

  // named access events for the assertions
  logic ev_otp_wr, ev_ctrl_wr, ev_auth_wr, ev_test_wr, ev_ignored;

  rb_decode #(
    .OTP_DEPTH(OTP_DEPTH), .CTRL_REGS(CTRL_REGS),
    .AUTH_REGS(AUTH_REGS), .TEST_REGS(TEST_REGS)
  ) u_dec (
    .valid(acc_valid), .bank(acc_bank), .offset(acc_offset),
    .test_mode(test_mode), .region(region), .deny(deny)
  );

  assign wr_any     = acc_valid && acc_write;
  assign rd_any     = acc_valid && !acc_write;
  assign ev_otp_wr  = wr_any && region == RGN_OTP;
  assign ev_ctrl_wr = wr_any && region == RGN_CTRL;
  assign ev_auth_wr = wr_any && region == RGN_AUTH;
  assign ev_test_wr = wr_any && region == RGN_TEST;
  assign ev_ignored = acc_valid && region == RGN_NONE;

  rb_otp_array #(.DEPTH(OTP_DEPTH), .DEF_CFG(DEF_CFG), .DEF_TRIM(DEF_TRIM)) u_otp (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_otp_wr), .idx(acc_offset),
    .wdata(acc_wdata), .mem(otp_mem)
  );

  rb_plain_regs #(.NUM(CTRL_REGS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_ctrl_wr), .idx(acc_offset),
    .wdata(acc_wdata), .rdata(ctrl_rd)
  );

  rb_plain_regs #(.NUM(AUTH_REGS)) u_auth (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_auth_wr), .idx(acc_offset),
    .wdata(acc_wdata), .rdata(auth_rd)
  );

  rb_plain_regs #(.NUM(TEST_REGS)) u_test (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_test_wr), .idx(acc_offset),
    .wdata(acc_wdata), .rdata(test_rd)
  );

  rb_live_cfg #(.DEF_CFG(DEF_CFG), .DEF_TRIM(DEF_TRIM)) u_live (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .src_cfg(otp_mem[0]), .src_trim(otp_mem[1]),
    .live_cfg(live_cfg), .live_trim(live_trim)
  );

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RGN_OTP:  if (!in_secret(acc_offset, SEC_FIRST, SEC_N))
                  rd_mux = otp_mem[acc_offset[OIW-1:0]];
      RGN_CTRL: rd_mux = ctrl_rd;
      RGN_AUTH: rd_mux = auth_rd;
      RGN_TEST: rd_mux = test_rd;
      default:  rd_mux = '0;
    endcase
  end

  assign rd_data = rd_any ? rd_mux : '0;
  assign bus_err = deny;

  for (genvar k = 0; k < SEC_N; k++) begin : g_sec
    assign secret_key[8*k +: 8] = otp_mem[SEC_FIRST + k];
  end

  assign {cfg_hi_sel, cfg_speed, cfg_irq_en, cfg_auto_sleep, cfg_lo_sel} = live_cfg;
  assign {trim_flag, trim_bias, trim_osc} = live_trim;

  AST_IGNORED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ignored |-> (rd_data == '0) && !bus_err); // R4

  AST_DENY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> rd_data == '0); // R5

  AST_DENY_ONLY_BANK3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> acc_valid && acc_bank == 2'd3 && !test_mode); // R5

  AST_TEST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !bus_err); // R6

  AST_DENY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !(ev_otp_wr || ev_ctrl_wr || ev_auth_wr || ev_test_wr)); // R5

endmodule

// File: tb/cfg_regbank_bench.sv
`timescale 1ns/1ps
module cfg_regbank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        test_mode = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_bank = '0;
  logic [7:0]  acc_offset = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data;
  logic        bus_err;
  logic [1:0]  cfg_hi_sel, cfg_speed, cfg_lo_sel;
  logic        cfg_irq_en, cfg_auto_sleep, trim_flag;
  logic [2:0]  trim_bias;
  logic [3:0]  trim_osc;
  logic [95:0] secret_key;

  always #2 clk = ~clk;

  cfg_regbank u_cfg_regbank (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .test_mode(test_mode),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_bank(acc_bank),
    .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .bus_err(bus_err), .cfg_hi_sel(cfg_hi_sel), .cfg_speed(cfg_speed),
    .cfg_irq_en(cfg_irq_en), .cfg_auto_sleep(cfg_auto_sleep),
    .cfg_lo_sel(cfg_lo_sel), .trim_flag(trim_flag), .trim_bias(trim_bias),
    .trim_osc(trim_osc), .secret_key(secret_key)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_otp [16];
  logic [7:0] m_ctrl [2];
  logic [7:0] m_auth [3];
  logic [7:0] m_test [8];
  logic [7:0] m_cfg, m_trim;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] b, input logic [7:0] o, input logic tm);
    case (b)
      2'd0: return (o < 16 && !(o >= 2 && o <= 13)) ? m_otp[o[3:0]] : 8'h00;
      2'd1: return (o < 2) ? m_ctrl[o[0]] : 8'h00;
      2'd2: return (o < 3) ? m_auth[o[1:0]] : 8'h00;
      default: return (tm && o < 8) ? m_test[o[2:0]] : 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] b, input logic [7:0] o, input logic tm);
    if (b == 2'd3) return tm ? "R6" : "R5";
    if (b == 2'd0 && o < 16) return (o >= 2 && o <= 13) ? "R9" : "R1";
    if ((b == 2'd1 && o < 2) || (b == 2'd2 && o < 3)) return "R3";
    return "R4";
  endfunction

  function automatic logic [95:0] exp_key();
    logic [95:0] k;
    for (int i = 0; i < 12; i++) k[8*i +: 8] = m_otp[2 + i];
    return k;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_otp[i] = 8'h00;
    m_otp[0] = 8'h24; m_otp[1] = 8'h08;
    for (int i = 0; i < 2; i++) m_ctrl[i] = 8'h00;
    for (int i = 0; i < 3; i++) m_auth[i] = 8'h00;
    for (int i = 0; i < 8; i++) m_test[i] = 8'h00;
    m_cfg = 8'h24; m_trim = 8'h08;
  endtask

  task automatic check_live(input string tag);
    chk(tag, {cfg_hi_sel, cfg_speed, cfg_irq_en, cfg_auto_sleep, cfg_lo_sel}, m_cfg);
    chk(tag, {trim_flag, trim_bias, trim_osc}, m_trim);
  endtask

  // one access cycle, optionally with a concurrent soft reset
  task automatic access(input logic w, input logic [1:0] b, input logic [7:0] o,
                        input logic [7:0] d, input logic tm, input logic srst);
    logic err;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_bank = b; acc_offset = o;
    acc_wdata = d; test_mode = tm; soft_rst = srst;
    #1;
    err = (b == 2'd3) && !tm;
    chk(err ? "R5" : (tm ? "R6" : "R4"), bus_err, err);
    if (!w) chk(tag_of(b, o, tm), rd_data, exp_rd(b, o, tm));
    @(posedge clk);
    if (srst) begin m_cfg = m_otp[0]; m_trim = m_otp[1]; end
    if (w && !err) begin
      if (b == 2'd0 && o < 16) m_otp[o[3:0]] = m_otp[o[3:0]] | d;
      else if (b == 2'd1 && o < 2) m_ctrl[o[0]] = d;
      else if (b == 2'd2 && o < 3) m_auth[o[1:0]] = d;
      else if (b == 2'd3 && o < 8) m_test[o[2:0]] = d;
    end
    @(negedge clk);
    acc_valid = 1'b0; soft_rst = 1'b0;
    #1;
    check_live(srst ? "R8" : "R7");
    chk("R9", secret_key, exp_key());
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] o;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10", {cfg_hi_sel, cfg_speed, cfg_irq_en, cfg_auto_sleep, cfg_lo_sel}, 8'h24);
    chk("R10", {trim_flag, trim_bias, trim_osc}, 8'h08);
    chk("R10", secret_key, 96'h0);
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 1'b0);      // R10 array default
    access(1'b0, 2'd0, 8'h01, 8'h00, 1'b0, 1'b0);
    access(1'b0, 2'd1, 8'h01, 8'h00, 1'b0, 1'b0);      // R3 reset 0
    // R2: bits only set
    access(1'b1, 2'd0, 8'h0F, 8'h5A, 1'b0, 1'b0);
    access(1'b1, 2'd0, 8'h0F, 8'hA1, 1'b0, 1'b0);
    access(1'b0, 2'd0, 8'h0F, 8'h00, 1'b0, 1'b0);
    chk("R2", m_otp[15], 8'hFB);
    // R7 then R8: deferred configuration and field placement
    access(1'b1, 2'd0, 8'h00, 8'h81, 1'b0, 1'b0);
    chk("R7", {cfg_hi_sel, cfg_speed, cfg_irq_en, cfg_auto_sleep, cfg_lo_sel}, 8'h24);
    access(1'b0, 2'd1, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R8", {cfg_hi_sel, cfg_speed, cfg_irq_en, cfg_auto_sleep, cfg_lo_sel, 30'h0},
        {2'd2, 2'd2, 1'b0, 1'b1, 2'd1, 30'h0});
    // R11: soft reset together with a trim write
    access(1'b1, 2'd0, 8'h01, 8'h02, 1'b0, 1'b1);
    chk("R11", {trim_flag, trim_bias, trim_osc}, 8'h08);
    access(1'b0, 2'd2, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R11", trim_osc, 4'hA);
    // R11 on the configuration byte
    access(1'b1, 2'd0, 8'h00, 8'h10, 1'b0, 1'b1);
    chk("R11", cfg_speed, 2'd2);
    // R5: denied test bank access leaves the scratch untouched
    access(1'b1, 2'd3, 8'h03, 8'hEE, 1'b0, 1'b0);
    access(1'b0, 2'd3, 8'h03, 8'h00, 1'b1, 1'b0);
    chk("R5", m_test[3], 8'h00);
    // R6: scratch in test mode, out-of-range offset ignored
    access(1'b1, 2'd3, 8'h07, 8'h3C, 1'b1, 1'b0);
    access(1'b0, 2'd3, 8'h07, 8'h00, 1'b1, 1'b0);
    access(1'b1, 2'd3, 8'h08, 8'h55, 1'b1, 1'b0);
    access(1'b0, 2'd3, 8'h08, 8'h00, 1'b1, 1'b0);
    // R9: secret hidden from host, exported on the key bus
    access(1'b1, 2'd0, 8'h05, 8'h77, 1'b0, 1'b0);
    access(1'b0, 2'd0, 8'h05, 8'h00, 1'b0, 1'b0);
    chk("R9", secret_key[8*3 +: 8], 8'h77);
    // R4: unimplemented locations
    access(1'b1, 2'd1, 8'h10, 8'hFF, 1'b0, 1'b0);
    access(1'b0, 2'd1, 8'h10, 8'h00, 1'b0, 1'b0);
    access(1'b1, 2'd0, 8'h40, 8'hFF, 1'b0, 1'b0);
    access(1'b0, 2'd0, 8'h40, 8'h00, 1'b0, 1'b0);
    access(1'b1, 2'd2, 8'h03, 8'hFF, 1'b0, 1'b0);
    access(1'b0, 2'd2, 8'h02, 8'h00, 1'b0, 1'b0);       // R3 still zero
    // random phase
    for (int n = 0; n < 800; n++) begin
      o = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 18);
      access(1'($urandom), 2'($urandom), o, ($urandom % 3 == 0) ? 8'($urandom) : 8'(1 << ($urandom % 8)),
             ($urandom % 3) != 0, ($urandom % 10) == 0);
    end
    // read back everything at the end
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 18; i++)
        access(1'b0, 2'(b), 8'(i), 8'h00, 1'b1, 1'b0);
    done = 1;
    summary();
    $finish;
  end

endmodule